// File: doc/BRIEF.md
# Indirect-Indexed Codec Register File

This block is the control register space of an audio codec interface, as seen from a 32-bit bus. It holds two banks of registers. The first bank has sixteen 32-bit registers, and each is selected directly by the bus address. The second bank has thirty-two 8-bit registers, and the bus cannot address them directly. Software writes an index into the first direct register and then moves data through the second direct register, which acts as a window onto the selected 8-bit register.

Some registers have fixed rules. A few are read-only or write-only. One keeps a single writable bit on top of a fixed identity code, and another returns a fixed chip identity. Writing bit 0 of a control register clears both banks to their reset values at once. The hardware reset input gives the same values. Bus reads are combinational: data is valid in the same cycle as the read strobe and the address.

Top module: `codec_regfile`

## Requirements
- R1: The direct register is selected by address bits [5:2]. All other address bits are ignored, so addresses that differ only in those bits reach the same register.
- R2: A write to any direct register other than 1, 2 and 4 stores all 32 bits. A read with `rd_en` high returns the selected register in the same cycle. When `rd_en` is low, `rdata` is 0.
- R3: The low 5 bits of direct register 0 form the index. A read of direct register 1 returns the indexed 8-bit register, zero-extended to 32 bits. A write to direct register 1 stores `wdata[7:0]` into the indexed register.
- R4: Indirect register 3 is write-only. Writes to it are accepted, but a read through direct register 1 returns 0.
- R5: Indirect registers 11 and 25 are read-only, and writes to them have no effect. Register 25 always reads 0xA0 and register 11 always reads 0.
- R6: A write to indirect register 12 stores `(wdata & 0x40) | 0x8A`. Only bit 6 is writable.
- R7: Direct register 2 is read-only. It reads 0, and writes to it have no effect.
- R8: A write to direct register 4 stores `wdata & 0x7F`. If `wdata[0]` is 1, the same write also returns every other register of both banks to its reset value. In that cycle the clear takes priority over every other update, except the masked value stored in register 4.
- R9: After `rst`, every register reads 0, except indirect register 12, which reads 0x8A, and indirect register 25, which reads 0xA0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, taken at the rising edge |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Bus byte address |
| wdata | input | 32 | Bus write data |
| rdata | output | 32 | Bus read data, combinational |

## Verification
A write takes effect at the next rising edge, so its result is first visible one cycle after the strobe. A read result is due in the same cycle as its strobe, before the edge. The bench drives the inputs just after the falling edge and compares `rdata` with the reference model a nanosecond later. Only then does it apply the write of that cycle to the model, so a read and a write in the same cycle are compared against the state before the write. The soft clear and the masked store into register 4 both become visible on the cycle after the triggering write, and the checks there expect both together.

// File: rtl/codec_reg_pkg.sv
`timescale 1ns/1ps
package codec_reg_pkg;

    // bank geometry
    localparam int REG_W      = 32;
    localparam int DIR_CNT    = 16;
    localparam int DIR_SEL_W  = $clog2(DIR_CNT);
    localparam int IND_CNT    = 32;
    localparam int IND_IDX_W  = $clog2(IND_CNT);
    localparam int IND_W      = 8;

    // direct register roles
    localparam int SEL_INDEX  = 0;
    localparam int SEL_PORT   = 1;
    localparam int SEL_LOCKED = 2;
    localparam int SEL_CTRL   = 4;

    // indirect register roles
    localparam int IND_WONLY  = 3;
    localparam int IND_RO_A   = 11;
    localparam int IND_MASKED = 12;
    localparam int IND_RO_B   = 25;

    localparam logic [IND_W-1:0] CODEC_ID    = 8'h8A;
    localparam logic [IND_W-1:0] CHIP_ID     = 8'hA0;
    localparam logic [IND_W-1:0] MASKED_KEEP = 8'h40;
    localparam int               CTRL_KEEP_W = 7;

    typedef enum logic [1:0] {
        K_PLAIN,
        K_RDONLY,
        K_WRONLY,
        K_MASKED
    } ind_kind_e;

    typedef struct packed {
        logic [DIR_CNT-1:0] dir_we;   // plain full-width stores
        logic               port_we;  // write through the data window
        logic               ctrl_we;  // write of the control register
        logic               soft_clr; // control write with bit 0 set
    } wr_dec_t;

    function automatic ind_kind_e ind_kind(input int i);
        case (i)
            IND_WONLY:           return K_WRONLY;
            IND_RO_A, IND_RO_B:  return K_RDONLY;
            IND_MASKED:          return K_MASKED;
            default:             return K_PLAIN;
        endcase
    endfunction

    function automatic logic [IND_W-1:0] ind_reset_val(input int i);
        case (i)
            IND_MASKED: return CODEC_ID;
            IND_RO_B:   return CHIP_ID;
            default:    return '0;
        endcase
    endfunction

    function automatic logic [IND_W-1:0] masked_store(input logic [IND_W-1:0] d);
        return (d & MASKED_KEEP) | CODEC_ID;
    endfunction

endpackage

// File: rtl/codec_addr_dec.sv
`timescale 1ns/1ps
module codec_addr_dec
    import codec_reg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wdata_lsb,
    output logic [DIR_SEL_W-1:0] sel,
    output wr_dec_t              dec
);

    logic unused_addr_bits;
    assign unused_addr_bits = ^{addr[ADDR_W-1:DIR_SEL_W+2], addr[1:0]};

    assign sel = addr[DIR_SEL_W+1:2];

    for (genvar j = 0; j < DIR_CNT; j++) begin : g_we
        if (j == SEL_PORT || j == SEL_LOCKED || j == SEL_CTRL) begin : g_special
            assign dec.dir_we[j] = 1'b0;
        end else begin : g_plain
            assign dec.dir_we[j] = wr_en && (sel == DIR_SEL_W'(j));
        end
    end

    assign dec.port_we  = wr_en && (sel == DIR_SEL_W'(SEL_PORT));
    assign dec.ctrl_we  = wr_en && (sel == DIR_SEL_W'(SEL_CTRL));
    assign dec.soft_clr = dec.ctrl_we && wdata_lsb;

endmodule

// File: rtl/codec_dir_bank.sv
`timescale 1ns/1ps
module codec_dir_bank
    import codec_reg_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           clr,
    input  wr_dec_t                        dec,
    input  logic [REG_W-1:0]               wdata,
    output logic [DIR_CNT-1:0][REG_W-1:0]  q
);

    for (genvar j = 0; j < DIR_CNT; j++) begin : g_reg
        if (j == SEL_PORT || j == SEL_LOCKED) begin : g_nostore
            assign q[j] = '0;
        end else if (j == SEL_CTRL) begin : g_ctrl
            always_ff @(posedge clk) begin
                if (rst)
                    q[j] <= '0;
                else if (dec.ctrl_we)
                    q[j] <= {{(REG_W-CTRL_KEEP_W){1'b0}}, wdata[CTRL_KEEP_W-1:0]};
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (clr)
                    q[j] <= '0;
                else if (dec.dir_we[j])
                    q[j] <= wdata;
            end
        end
    end

endmodule

// File: rtl/codec_ind_bank.sv
`timescale 1ns/1ps
module codec_ind_bank
    import codec_reg_pkg::*;
(
    input  logic                  clk,
    input  logic                  clr,
    input  logic                  we,
    input  logic [IND_IDX_W-1:0]  idx,
    input  logic [IND_W-1:0]      wdata,
    output logic [IND_W-1:0]      rdata
);

    logic [IND_CNT-1:0][IND_W-1:0] q;

    for (genvar i = 0; i < IND_CNT; i++) begin : g_reg
        localparam ind_kind_e KIND = ind_kind(i);
        if (KIND == K_RDONLY) begin : g_const
            assign q[i] = ind_reset_val(i);
        end else begin : g_store
            always_ff @(posedge clk) begin
                if (clr)
                    q[i] <= ind_reset_val(i);
                else if (we && idx == IND_IDX_W'(i))
                    q[i] <= (KIND == K_MASKED) ? masked_store(wdata) : wdata;
            end
        end
    end

    always_comb begin
        if (ind_kind(int'(idx)) == K_WRONLY)
            rdata = '0;
        else
            rdata = q[idx];
    end

endmodule

// File: rtl/codec_regfile.sv
`timescale 1ns/1ps
module codec_regfile
    import codec_reg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata
);

    logic [DIR_SEL_W-1:0]          sel;
    wr_dec_t                       dec;
    logic                          clr;
    logic [DIR_CNT-1:0][REG_W-1:0] dir_q;
    logic [IND_IDX_W-1:0]          ind_idx;
    logic [IND_W-1:0]              ind_rdata;

    codec_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata_lsb (wdata[0]),
        .sel       (sel),
        .dec       (dec)
    );

    assign clr = rst || dec.soft_clr;

    codec_dir_bank u_dir (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .dec   (dec),
        .wdata (wdata),
        .q     (dir_q)
    );

    assign ind_idx = dir_q[SEL_INDEX][IND_IDX_W-1:0];

    codec_ind_bank u_ind (
        .clk   (clk),
        .clr   (clr),
        .we    (dec.port_we),
        .idx   (ind_idx),
        .wdata (wdata[IND_W-1:0]),
        .rdata (ind_rdata)
    );

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (sel == DIR_SEL_W'(SEL_PORT))
                rdata = {{(REG_W-IND_W){1'b0}}, ind_rdata};
            else
                rdata = dir_q[sel];
        end
    end

endmodule

// File: rtl/codec_regfile_chk.sv
`timescale 1ns/1ps
module codec_regfile_chk
    import codec_reg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en,
    input logic                 rd_en,
    input logic [ADDR_W-1:0]    addr,
    input logic [31:0]          wdata,
    input logic [31:0]          rdata,
    input logic [IND_IDX_W-1:0] cur_index
);

    logic [DIR_SEL_W-1:0] s;
    assign s = addr[DIR_SEL_W+1:2];

    logic port_rd;
    assign port_rd = rd_en && s == DIR_SEL_W'(SEL_PORT);

    assert_port_zero_ext_R3: assert property (@(posedge clk) disable iff (rst)
        port_rd |-> rdata[31:IND_W] == '0);

    assert_wonly_reads_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (port_rd && cur_index == IND_IDX_W'(IND_WONLY)) |-> rdata == '0);

    assert_chip_id_R5: assert property (@(posedge clk) disable iff (rst)
        (port_rd && cur_index == IND_IDX_W'(IND_RO_B)) |-> rdata == 32'(CHIP_ID));

    assert_masked_id_R6: assert property (@(posedge clk) disable iff (rst)
        (port_rd && cur_index == IND_IDX_W'(IND_MASKED)) |-> (rdata & ~32'h40) == 32'(CODEC_ID));

    assert_locked_reads_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && s == DIR_SEL_W'(SEL_LOCKED)) |-> rdata == '0);

    assert_soft_clr_index_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && s == DIR_SEL_W'(SEL_CTRL) && wdata[0]) |=> cur_index == '0);

    assert_index_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (s == DIR_SEL_W'(SEL_INDEX) || (s == DIR_SEL_W'(SEL_CTRL) && wdata[0])))
        |=> $stable(cur_index));

    assert_idle_read_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> rdata == '0);

endmodule

bind codec_regfile codec_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .cur_index (ind_idx)
);

// File: tb/tb_codec_regfile.sv
`timescale 1ns/1ps
module tb_codec_regfile;

    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_en;
    logic          rd_en;
    logic [AW-1:0] addr;
    logic [31:0]   wdata;
    logic [31:0]   rdata;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    // behavioural reference state
    int unsigned m_dir [16];
    int unsigned m_ind [32];

    always #2.5 clk = ~clk;

    codec_regfile #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    function automatic void m_reset();
        foreach (m_dir[k]) m_dir[k] = 0;
        foreach (m_ind[k]) m_ind[k] = 0;
        m_ind[12] = 'h8A;
        m_ind[25] = 'hA0;
    endfunction

    function automatic int unsigned m_read(input bit rd, input logic [AW-1:0] a);
        int sa;
        int ix;
        if (!rd) return 0;
        sa = int'(a[5:2]);
        ix = int'(m_dir[0] % 32);
        if (sa == 1) return (ix == 3) ? 0 : m_ind[ix];
        return m_dir[sa];
    endfunction

    function automatic void m_write(input logic [AW-1:0] a, input int unsigned d);
        int sa;
        int ix;
        sa = int'(a[5:2]);
        ix = int'(m_dir[0] % 32);
        if (sa == 1) begin
            if (ix == 12)                 m_ind[ix] = (d & 'h40) | 'h8A;
            else if (ix != 11 && ix != 25) m_ind[ix] = d & 'hFF;
        end else if (sa == 4) begin
            if (d[0]) m_reset();
            m_dir[4] = d & 'h7F;
        end else if (sa != 2) begin
            m_dir[sa] = d;
        end
    endfunction

    function automatic string tag_of(input bit rd, input logic [AW-1:0] a);
        int sa;
        int ix;
        sa = int'(a[5:2]);
        ix = int'(m_dir[0] % 32);
        if (!rd) return "R2";
        if (sa == 1) begin
            if (ix == 3) return "R4";
            if (ix == 11 || ix == 25) return "R5";
            if (ix == 12) return "R6";
            return "R3";
        end
        if (sa == 2) return "R7";
        if (sa == 4) return "R8";
        return "R2";
    endfunction

    // one bus cycle: drive, compare before the edge, then advance the model
    task automatic cyc(input bit w, input bit r, input logic [AW-1:0] a,
                       input logic [31:0] d, input string tag);
        int unsigned exp;
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d;
        #1;
        exp = m_read(r, a);
        vectors++;
        if (rdata !== exp) begin
            misses++;
            $display("FAIL %s addr=%02h actual=%08h expected=%08h", tag, a, rdata, exp);
        end
        if (w && !rst) m_write(a, d);
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        cyc(1'b0, 1'b1, a, 32'h0, tag);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input string tag);
        cyc(1'b1, 1'b0, a, d, tag);
    endtask

    task automatic rd_ind(input int ix, input string tag);
        wr(8'h00, 32'(ix), tag);
        rd(8'h04, tag);
    endtask

    initial begin
        wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
        rst = 1'b1;
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R9: reset values in both banks
        for (int k = 0; k < 16; k++) rd(AW'(k * 4), "R9");
        for (int k = 0; k < 32; k++) rd_ind(k, "R9");

        // R1: upper and low address bits ignored
        wr(8'h5D, 32'hDEAD_BEEF, "R1");
        rd(8'h1C, "R1");
        rd(8'hDE, "R1");

        // R2: full-width store, idle read returns 0
        wr(8'h20, 32'hFFFF_FFFF, "R2");
        rd(8'h20, "R2");
        cyc(1'b0, 1'b0, 8'h20, 32'h0, "R2");

        // R3: indirect plain store and zero extension
        wr(8'h00, 32'hFFFF_FFE7, "R3");
        wr(8'h04, 32'h1234_56C3, "R3");
        rd(8'h04, "R3");
        rd(8'h00, "R3");

        // R4: write-only indirect
        wr(8'h00, 32'd3, "R4");
        wr(8'h04, 32'h55, "R4");
        rd(8'h04, "R4");

        // R5: read-only indirect registers
        wr(8'h00, 32'd11, "R5");
        wr(8'h04, 32'hFF, "R5");
        rd(8'h04, "R5");
        wr(8'h00, 32'd25, "R5");
        wr(8'h04, 32'h00, "R5");
        rd(8'h04, "R5");

        // R6: masked indirect register
        wr(8'h00, 32'd12, "R6");
        wr(8'h04, 32'hFF, "R6");
        rd(8'h04, "R6");
        wr(8'h04, 32'h00, "R6");
        rd(8'h04, "R6");

        // R7: locked direct register
        wr(8'h08, 32'hA5A5_A5A5, "R7");
        rd(8'h08, "R7");

        // R8: control store without clear, then soft clear with write in same cycle
        wr(8'h00, 32'd7, "R8");
        wr(8'h04, 32'h99, "R8");
        wr(8'h10, 32'hFFFF_FFFE, "R8");
        rd(8'h10, "R8");
        rd_ind(7, "R8");
        wr(8'h00, 32'd7, "R8");
        cyc(1'b1, 1'b1, 8'h10, 32'h0000_0183, "R8");
        rd(8'h10, "R8");
        rd(8'h00, "R8");
        rd(8'h20, "R8");
        rd(8'h1C, "R8");
        rd_ind(7, "R8");
        rd_ind(12, "R8");

        // mixed traffic against the reference model
        for (int n = 0; n < 3000; n++) begin
            logic [AW-1:0] a;
            logic [31:0]   d;
            bit            w;
            a = AW'($urandom);
            d = $urandom;
            w = ($urandom % 2) == 1;
            if (a[5:2] == 4'd0) d = d % 40;
            if (a[5:2] == 4'd4 && ($urandom % 16) != 0) d[0] = 1'b0;
            cyc(w, 1'b1, a, d, tag_of(1'b1, a));
        end

        // R9: hardware reset after traffic
        @(negedge clk);
        rst = 1'b1; wr_en = 0;
        @(negedge clk);
        rst = 1'b0;
        m_reset();
        for (int k = 0; k < 16; k++) rd(AW'(k * 4), "R9");
        rd_ind(12, "R9");
        rd_ind(25, "R9");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            misses++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule